// File: doc/BRIEF.md
# Eight-Input Prioritised Interrupt Controller

This block collects interrupt requests from up to eight peripheral lines and presents one interrupt line to a processor. When the processor acknowledges, the block returns an 8-bit vector type number for the chosen request. It keeps three registers of state:
- a pending register, where a bit is set by a rising edge on its request line;
- a service register, which holds the interrupts that have been acknowledged but not yet finished;
- a mask register, where a set bit stops its input from raising the interrupt.

Priority is fixed, and input 0 has the highest priority.

Software uses a one-bit address port. It first writes a short setup sequence:
1. a start word;
2. the vector base;
3. the initial mask.

Only after that sequence are run-time command words accepted. Command words can end the current service, change the mask, or choose which register is read back. A service routine ends with an end-of-service command, which frees the highest-priority entry in the service register and so re-opens lower-priority inputs.

Top module: `irq_ctl`

## Requirements
- R1: After reset, `int_o` is low, the mask register is 8'hFF, the pending and service registers are zero, the read selector points at the pending register, the vector base is zero and the block is unconfigured.
- R2: Until the setup sequence is complete, `int_o` stays low, and every write other than a start word or an expected setup word is ignored. Ignored writes include run-time commands at address 0 and mask writes at address 1.
- R3: A write at address 0 with bit 4 set is a start word. It clears the pending and service registers, points the read selector at the pending register and starts the setup sequence. The next address-1 write loads the vector base from bits 7:3. The address-1 write after that loads the mask and makes the block operational.
- R4: Each rising edge on `req_i[k]` sets pending bit k. A line held high does not set the bit again. The bit stays set until it is acknowledged or a start word is written.
- R5: `int_o` is high exactly when the block is operational and some pending, unmasked bit has a lower index than every set service bit.
- R6: While `ack_i` is high, `vec_o` equals the vector base in bits 7:3 and, in bits 2:0, the lowest index that qualifies under R5. When `ack_i` is low, `vec_o` is zero.
- R7: At a clock edge with `ack_i` high and `int_o` high, the chosen pending bit is cleared and the matching service bit is set.
- R8: When operational, a write at address 0 with bit 4 clear, bit 3 clear and bit 5 set is an end-of-service command. It clears the lowest-index set service bit. If the service register is empty, it has no effect.
- R9: When operational, a write at address 1 loads the mask register. Reading at address 1 returns the mask register.
- R10: When operational, a write at address 0 with bit 4 clear and bit 3 set chooses what address 0 reads back: the service register if bit 0 is 1, the pending register if bit 0 is 0.
- R11: An acknowledge while no input qualifies returns the vector base with index 7 and changes neither the pending register nor the service register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address bit |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data: the mask register at address 1, the selected register at address 0 |
| req_i | input | 8 | Peripheral request lines, edge-detected |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Acknowledge from the processor |
| vec_o | output | 8 | Vector type number, driven while `ack_i` is high |

## Verification
The assertions check on every cycle that:
- `int_o` never rises without an unmasked pending source while the block is operational;
- the vector always carries the programmed base during an acknowledge and is zero otherwise;
- an acknowledge adds exactly one service bit;
- an end-of-service command removes exactly one service bit;
- a start word empties the pending and service registers.

Only the bench scenarios can show the following:
- which input wins when several compete;
- that nested service blocks lower-priority requests and lets higher-priority ones through;
- that held request levels do not re-trigger;
- that writes made before or during setup are ignored;
- the exact vector values returned.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

   typedef enum logic [1:0] {
      CFG_IDLE,
      CFG_BASE,
      CFG_MASK,
      CFG_RUN
   } cfg_state_e;

   // command-word bit positions decoded at address 0
   localparam int unsigned CMD_START_POS = 4;
   localparam int unsigned CMD_SEL_POS   = 3;
   localparam int unsigned CMD_EOI_POS   = 5;
   localparam int unsigned CMD_RSEL_POS  = 0;

endpackage

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
   parameter int unsigned N_IN        = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] req_i,
   input  logic            clear_all_i,
   input  logic            ack_take_i,
   input  logic [N_IN-1:0] ack_onehot_i,
   output logic [N_IN-1:0] irr_o
);

   logic [N_IN-1:0] req_s;
   logic [N_IN-1:0] prev_q;
   logic [N_IN-1:0] irr_q;
   logic [N_IN-1:0] rise;
   logic [N_IN-1:0] take_mask;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign req_s = req_i;
      end else begin : g_sync
         logic [N_IN-1:0] sync_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
            end else begin
               sync_q[0] <= req_i;
               for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
            end
         end
         assign req_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   assign rise      = req_s & ~prev_q;
   assign take_mask = ack_take_i ? ack_onehot_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         irr_q  <= '0;
      end else begin
         prev_q <= req_s;
         if (clear_all_i) irr_q <= '0;
         else             irr_q <= (irr_q & ~take_mask) | rise;
      end
   end

   assign irr_o = irr_q;

endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int unsigned N_IN = 8,
   localparam int unsigned IDX_W = $clog2(N_IN)
) (
   input  logic [N_IN-1:0]  irr_i,
   input  logic [N_IN-1:0]  imr_i,
   input  logic [N_IN-1:0]  isr_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N_IN-1:0]  hit_onehot_o,
   output logic [N_IN-1:0]  isr_top_o
);

   logic [N_IN-1:0] cand;
   logic [N_IN-1:0] allowed;
   logic [N_IN-1:0] qual;
   logic [N_IN-1:0] isr_top;

   always_comb begin
      cand    = irr_i & ~imr_i;
      isr_top = isr_i & (~isr_i + N_IN'(1));
      allowed = (isr_i == '0) ? '1 : (isr_top - N_IN'(1));
      qual    = cand & allowed;
      idx_o   = '1;
      for (int i = N_IN - 1; i >= 0; i--) begin
         if (qual[i]) idx_o = IDX_W'(i);
      end
   end

   assign hit_o        = |qual;
   assign hit_onehot_o = qual & (~qual + N_IN'(1));
   assign isr_top_o    = isr_top;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_ctl_pkg::*;
#(
   parameter int unsigned N_IN = 8,
   parameter int unsigned DW   = 8,
   localparam int unsigned IDX_W  = $clog2(N_IN),
   localparam int unsigned BASE_W = DW - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              addr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic              ack_take_i,
   input  logic [N_IN-1:0]   ack_onehot_i,
   input  logic [N_IN-1:0]   isr_top_i,
   output logic              ready_o,
   output logic [BASE_W-1:0] base_o,
   output logic [N_IN-1:0]   imr_o,
   output logic [N_IN-1:0]   isr_o,
   output logic              rsel_isr_o,
   output logic              start_o,
   output logic              eoi_o
);

   cfg_state_e        state_q;
   logic [BASE_W-1:0] base_q;
   logic [N_IN-1:0]   imr_q;
   logic [N_IN-1:0]   isr_q;
   logic              rsel_q;
   logic              run;
   logic              cmd_wr;
   logic              sel_wr;
   logic              hi_wr;
   logic [N_IN-1:0]   eoi_clr;
   logic [N_IN-1:0]   ack_set;

   assign run     = (state_q == CFG_RUN);
   assign hi_wr   = wr_en_i & addr_i;
   assign start_o = wr_en_i & ~addr_i & wdata_i[CMD_START_POS];
   assign cmd_wr  = wr_en_i & ~addr_i & ~wdata_i[CMD_START_POS] & run;
   assign eoi_o   = cmd_wr & ~wdata_i[CMD_SEL_POS] & wdata_i[CMD_EOI_POS];
   assign sel_wr  = cmd_wr & wdata_i[CMD_SEL_POS];
   assign eoi_clr = eoi_o ? isr_top_i : '0;
   assign ack_set = ack_take_i ? ack_onehot_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CFG_IDLE;
         base_q  <= '0;
         imr_q   <= '1;
         isr_q   <= '0;
         rsel_q  <= 1'b0;
      end else begin
         if (start_o) begin
            state_q <= CFG_BASE;
            isr_q   <= '0;
            rsel_q  <= 1'b0;
         end else begin
            isr_q <= (isr_q & ~eoi_clr) | ack_set;
            if (sel_wr) rsel_q <= wdata_i[CMD_RSEL_POS];
            if (hi_wr) begin
               unique case (state_q)
                  CFG_BASE: begin
                     base_q  <= wdata_i[DW-1:IDX_W];
                     state_q <= CFG_MASK;
                  end
                  CFG_MASK: begin
                     imr_q   <= wdata_i[N_IN-1:0];
                     state_q <= CFG_RUN;
                  end
                  CFG_RUN:  imr_q <= wdata_i[N_IN-1:0];
                  default:  state_q <= state_q;
               endcase
            end
         end
      end
   end

   assign ready_o    = run;
   assign base_o     = base_q;
   assign imr_o      = imr_q;
   assign isr_o      = isr_q;
   assign rsel_isr_o = rsel_q;

endmodule

// File: rtl/irq_ctl.sv
module irq_ctl #(
   parameter int unsigned N_IN        = 8,
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned IDX_W  = $clog2(N_IN),
   localparam int unsigned BASE_W = DW - IDX_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic            addr_i,
   input  logic [DW-1:0]   wdata_i,
   output logic [DW-1:0]   rdata_o,
   input  logic [N_IN-1:0] req_i,
   output logic            int_o,
   input  logic            ack_i,
   output logic [DW-1:0]   vec_o
);

   generate
      if (N_IN < 2 || (1 << IDX_W) != N_IN || N_IN > DW) begin : g_bad_cfg
         $error("irq_ctl: N_IN must be a power of two between 2 and DW");
      end
      if (DW <= IDX_W) begin : g_bad_dw
         $error("irq_ctl: DW must leave room for the vector base");
      end
   endgenerate

   logic              ready;
   logic [BASE_W-1:0] base;
   logic [N_IN-1:0]   imr;
   logic [N_IN-1:0]   isr;
   logic [N_IN-1:0]   irr;
   logic              rsel_isr;
   logic              start;
   logic              eoi;
   logic              hit;
   logic [IDX_W-1:0]  idx;
   logic [N_IN-1:0]   hit_onehot;
   logic [N_IN-1:0]   isr_top;
   logic              ack_take;

   assign int_o    = ready & hit;
   assign ack_take = ack_i & int_o;

   irq_cfg_regs #(.N_IN(N_IN), .DW(DW)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (wr_en_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .ack_take_i   (ack_take),
      .ack_onehot_i (hit_onehot),
      .isr_top_i    (isr_top),
      .ready_o      (ready),
      .base_o       (base),
      .imr_o        (imr),
      .isr_o        (isr),
      .rsel_isr_o   (rsel_isr),
      .start_o      (start),
      .eoi_o        (eoi)
   );

   irq_req_capture #(.N_IN(N_IN), .SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .clear_all_i  (start),
      .ack_take_i   (ack_take),
      .ack_onehot_i (hit_onehot),
      .irr_o        (irr)
   );

   irq_prio #(.N_IN(N_IN)) u_prio (
      .irr_i        (irr),
      .imr_i        (imr),
      .isr_i        (isr),
      .hit_o        (hit),
      .idx_o        (idx),
      .hit_onehot_o (hit_onehot),
      .isr_top_o    (isr_top)
   );

   always_comb begin
      if (addr_i)        rdata_o = DW'(imr);
      else if (rsel_isr) rdata_o = DW'(isr);
      else               rdata_o = DW'(irr);
   end

   assign vec_o = ack_i ? {base, idx} : '0;

endmodule

// File: rtl/irq_ctl_chk.sv
module irq_ctl_chk #(
   parameter int unsigned N_IN = 8,
   parameter int unsigned DW   = 8,
   localparam int unsigned IDX_W  = $clog2(N_IN),
   localparam int unsigned BASE_W = DW - IDX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_i,
   input logic              int_o,
   input logic [DW-1:0]     vec_o,
   input logic              ready,
   input logic [N_IN-1:0]   irr,
   input logic [N_IN-1:0]   imr,
   input logic [N_IN-1:0]   isr,
   input logic [BASE_W-1:0] base,
   input logic              eoi,
   input logic              start
);

   a_r5_int_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> (ready && ((irr & ~imr) != '0)));

   a_r2_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !int_o);

   a_r6_vec_base: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |-> (vec_o[DW-1:IDX_W] == base));

   a_r6_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |-> (vec_o == '0));

   a_r7_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && int_o && !eoi && !start) |=>
         ($countones(isr) == $countones($past(isr)) + 1));

   a_r8_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && (isr != '0) && !(ack_i && int_o)) |=>
         ($countones(isr) + 1 == $countones($past(isr))));

   a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> ((isr == '0) && (irr == '0)));

endmodule

bind irq_ctl irq_ctl_chk #(.N_IN(N_IN), .DW(DW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .ack_i (ack_i),
   .int_o (int_o),
   .vec_o (vec_o),
   .ready (ready),
   .irr   (irr),
   .imr   (imr),
   .isr   (isr),
   .base  (base),
   .eoi   (eoi),
   .start (start)
);

// File: tb/irq_ctl_bench.sv
`timescale 1ns/1ps
module irq_ctl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en_i = 1'b0;
   logic       addr_i = 1'b0;
   logic [7:0] wdata_i = '0;
   logic [7:0] rdata_o;
   logic [7:0] req_i = '0;
   logic       int_o;
   logic       ack_i = 1'b0;
   logic [7:0] vec_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   irq_ctl u_irq_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .req_i   (req_i),
      .int_o   (int_o),
      .ack_i   (ack_i),
      .vec_o   (vec_o)
   );

   localparam logic [2:0] K_WR  = 3'd0;
   localparam logic [2:0] K_RD  = 3'd1;
   localparam logic [2:0] K_REQ = 3'd2;
   localparam logic [2:0] K_ACK = 3'd3;
   localparam logic [2:0] K_INT = 3'd4;
   localparam int NV = 61;

   // {kind, addr, data, expected, requirement}
   localparam logic [23:0] TBL [NV] = '{
      {K_REQ, 1'b0, 8'h04, 8'h00, 4'd2},  // R2 edge before setup
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd2},  // R2 int held low
      {K_WR,  1'b1, 8'h00, 8'h00, 4'd2},  // R2 mask write ignored
      {K_RD,  1'b1, 8'h00, 8'hFF, 4'd2},
      {K_WR,  1'b0, 8'h10, 8'h00, 4'd3},  // R3 start word
      {K_RD,  1'b0, 8'h00, 8'h00, 4'd3},
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd3},
      {K_WR,  1'b1, 8'h20, 8'h00, 4'd3},  // base 0x20
      {K_WR,  1'b1, 8'h00, 8'h00, 4'd3},  // mask 0
      {K_RD,  1'b1, 8'h00, 8'h00, 4'd3},
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd4},  // R4 held level gives no edge
      {K_REQ, 1'b0, 8'h00, 8'h00, 4'd4},
      {K_REQ, 1'b0, 8'h28, 8'h00, 4'd4},
      {K_INT, 1'b0, 8'h00, 8'h01, 4'd5},  // R5
      {K_RD,  1'b0, 8'h00, 8'h28, 4'd4},
      {K_ACK, 1'b0, 8'h00, 8'h23, 4'd6},  // R6 lowest index wins
      {K_WR,  1'b0, 8'h09, 8'h00, 4'd10}, // R10 select service reg
      {K_RD,  1'b0, 8'h00, 8'h08, 4'd7},  // R7
      {K_WR,  1'b0, 8'h08, 8'h00, 4'd10},
      {K_RD,  1'b0, 8'h00, 8'h20, 4'd7},
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd5},  // lower than in-service
      {K_REQ, 1'b0, 8'h2A, 8'h00, 4'd4},
      {K_INT, 1'b0, 8'h00, 8'h01, 4'd5},  // nesting allowed
      {K_ACK, 1'b0, 8'h00, 8'h21, 4'd6},
      {K_WR,  1'b0, 8'h09, 8'h00, 4'd10},
      {K_RD,  1'b0, 8'h00, 8'h0A, 4'd7},
      {K_WR,  1'b0, 8'h20, 8'h00, 4'd8},  // R8 end of service
      {K_RD,  1'b0, 8'h00, 8'h08, 4'd8},
      {K_WR,  1'b0, 8'h20, 8'h00, 4'd8},
      {K_RD,  1'b0, 8'h00, 8'h00, 4'd8},
      {K_INT, 1'b0, 8'h00, 8'h01, 4'd5},
      {K_WR,  1'b1, 8'h20, 8'h00, 4'd9},  // R9 mask bit 5
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd9},
      {K_RD,  1'b1, 8'h00, 8'h20, 4'd9},
      {K_WR,  1'b1, 8'h00, 8'h00, 4'd9},
      {K_ACK, 1'b0, 8'h00, 8'h25, 4'd6},
      {K_WR,  1'b0, 8'h20, 8'h00, 4'd8},
      {K_RD,  1'b0, 8'h00, 8'h00, 4'd8},
      {K_WR,  1'b0, 8'h08, 8'h00, 4'd10},
      {K_RD,  1'b0, 8'h00, 8'h00, 4'd4},
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd5},
      {K_ACK, 1'b0, 8'h00, 8'h27, 4'd11}, // R11 spurious
      {K_WR,  1'b0, 8'h09, 8'h00, 4'd10},
      {K_RD,  1'b0, 8'h00, 8'h00, 4'd11},
      {K_WR,  1'b0, 8'h20, 8'h00, 4'd8},  // empty service reg
      {K_RD,  1'b0, 8'h00, 8'h00, 4'd8},
      {K_REQ, 1'b0, 8'h00, 8'h00, 4'd4},
      {K_REQ, 1'b0, 8'h80, 8'h00, 4'd4},
      {K_WR,  1'b0, 8'h10, 8'h00, 4'd3},  // restart
      {K_WR,  1'b0, 8'h09, 8'h00, 4'd2},  // ignored during setup
      {K_REQ, 1'b0, 8'hC0, 8'h00, 4'd4},
      {K_RD,  1'b0, 8'h00, 8'h40, 4'd2},
      {K_WR,  1'b1, 8'h48, 8'h00, 4'd3},
      {K_WR,  1'b1, 8'h3F, 8'h00, 4'd3},
      {K_INT, 1'b0, 8'h00, 8'h01, 4'd5},
      {K_ACK, 1'b0, 8'h00, 8'h4E, 4'd6},
      {K_REQ, 1'b0, 8'h40, 8'h00, 4'd4},
      {K_REQ, 1'b0, 8'hC0, 8'h00, 4'd4},
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd5},
      {K_RD,  1'b0, 8'h00, 8'h80, 4'd4},
      {K_INT, 1'b0, 8'h00, 8'h00, 4'd5}
   };

   task automatic check(input int rq, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic do_write(input logic a, input logic [7:0] d);
      addr_i  = a;
      wdata_i = d;
      wr_en_i = 1'b1;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(1, {7'b0, int_o}, 8'h00);
      check(1, vec_o, 8'h00);
      addr_i = 1'b1; #1;
      check(1, rdata_o, 8'hFF);
      addr_i = 1'b0; #1;
      check(1, rdata_o, 8'h00);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] kind;
         logic       a;
         logic [7:0] d;
         logic [7:0] e;
         int         rq;
         kind = TBL[i][23:21];
         a    = TBL[i][20];
         d    = TBL[i][19:12];
         e    = TBL[i][11:4];
         rq   = int'(TBL[i][3:0]);
         case (kind)
            K_WR:  do_write(a, d);
            K_RD:  begin addr_i = a; #1; check(rq, rdata_o, e); end
            K_REQ: begin req_i = d; @(negedge clk); end
            K_ACK: begin
               ack_i = 1'b1; #1;
               check(rq, vec_o, e);
               @(negedge clk);
               ack_i = 1'b0;
            end
            default: check(rq, {7'b0, int_o}, e);
         endcase
      end

      // R1 reset while running returns to the idle state
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      req_i = 8'h00;
      @(negedge clk);
      check(1, {7'b0, int_o}, 8'h00);
      addr_i = 1'b1; #1;
      check(1, rdata_o, 8'hFF);
      addr_i = 1'b0; #1;
      check(1, rdata_o, 8'h00);

      finish_run();
   end

endmodule